// File: doc/BRIEF.md
# Rotating-Slice Instruction Fetch Unit

This block fetches instructions with a ring of identical slices that take turns in a fixed order, one fetch per turn. Every slice keeps a small private direct-mapped instruction cache. A program-counter value belongs to exactly one slice: the one whose index equals the PC's low bits. No instruction word is ever held in two slices. The slice whose turn it is looks up the shared PC. If the PC belongs to that slice, it produces the instruction and advances the PC. If the PC belongs to another slice, it produces a NOP beat and leaves the PC unchanged, and the rotation moves on until it reaches the owning slice.

A miss in the active slice stops the rotation and reads the word over one shared backing-memory port. The word is written into that slice's cache, and the turn finishes with the fetched word. A branch redirect loads a new PC at the next turn boundary. A flush input invalidates every cache line at once. Each output beat carries the PC, the instruction word, a NOP flag and the producing slice, and it is held until the consumer takes it.

The controller has three states. LOOKUP is the start of a turn. REFILL is a memory read in flight. EMIT is a beat waiting on the consumer. The transitions are:
- LOOKUP→LOOKUP when a redirect is applied.
- LOOKUP→EMIT on a NOP turn or a cache hit.
- LOOKUP→REFILL on a miss.
- REFILL→EMIT when the read data returns.
- EMIT→LOOKUP when the beat is accepted, which also hands the turn to the next slice.

Top module: `rrf_fetch_top`

## Requirements
- R1: While reset is held, `out_valid` and `mem_req` are low. The first beat after reset comes from slice 0 and carries PC 0.
- R2: Accepted beats come from slices 0, 1, …, N−1, 0, … in strict order, one turn per accepted beat.
- R3: When the PC's low SB bits differ from the active slice index, the beat has `out_nop`=1 and an all-zero instruction word. The next beat carries the same PC.
- R4: When the PC belongs to the active slice and its line is valid with a matching tag, the beat carries the cached word with `out_nop`=0, and the PC advances by one.
- R5: On a miss, exactly one read is issued with `mem_addr` equal to the PC. `mem_req` stays high with a stable address until `mem_rvalid`. No beat is output during the read. The beat then carries `mem_rdata` from the same slice.
- R6: A word that is still cached is delivered without any memory read when its PC is visited again.
- R7: Placement is fixed. The slice is PC[SB−1:0], the line is PC[SB+LB−1:SB], and the tag is the PC bits above those. Every non-NOP beat satisfies `out_pc[SB-1:0]` = `out_slice`. Two PCs with the same slice and line but different tags evict each other.
- R8: A one-cycle `flush` pulse invalidates every line of every slice, so the next visit to any PC misses.
- R9: A redirect is applied at the next turn start. One that arrives while a turn is in progress is held until then. The next beat comes from the next slice in rotation and carries the target PC.
- R10: While `out_valid` is high and `out_ready` is low, the beat's four fields and `out_valid` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all cache lines |
| redir_valid | input | 1 | Branch redirect request |
| redir_pc | input | PC_W | Redirect target PC |
| mem_req | output | 1 | Backing-memory read outstanding |
| mem_addr | output | PC_W | Word address of the read |
| mem_rvalid | input | 1 | Read data valid, one-cycle pulse |
| mem_rdata | input | INSTR_W | Read data |
| out_valid | output | 1 | Beat available |
| out_ready | input | 1 | Consumer takes the beat |
| out_pc | output | PC_W | PC of the beat |
| out_instr | output | INSTR_W | Instruction word, zero on NOP beats |
| out_nop | output | 1 | Beat is a NOP turn |
| out_slice | output | SB | Index of the producing slice |

## Verification
A corrupted turn counter shows on the very next beat as a wrong `out_slice`, or as a NOP where the PC residue should have matched. A stale valid bit or a wrong tag shows at the first revisit of the affected line. Either a read appears where none was expected, or a beat arrives with no read and carries another PC's word. Conflicting loops and flushes make that revisit occur within a handful of turns. A lost redirect or a PC that advances on a NOP shows in the PC of the following beat.

// File: rtl/rrf_pkg.sv
package rrf_pkg;
    typedef enum logic [1:0] {
        ST_LOOKUP = 2'd0,
        ST_REFILL = 2'd1,
        ST_EMIT   = 2'd2
    } fetch_state_t;
endpackage

// File: rtl/rrf_turn_ring.sv
module rrf_turn_ring #(
    parameter int SLICES = 16,
    localparam int SB = $clog2(SLICES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [SB-1:0] turn
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            turn <= '0;
        end else if (step) begin
            turn <= (turn == SB'(SLICES - 1)) ? '0 : turn + SB'(1);
        end
    end
endmodule

// File: rtl/rrf_slice_cache.sv
module rrf_slice_cache #(
    parameter int LINE_BITS = 8,
    parameter int TAG_W     = 4,
    parameter int DATA_W    = 32,
    localparam int LINES = 1 << LINE_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush,
    input  logic [LINE_BITS-1:0] rd_idx,
    input  logic [TAG_W-1:0]     rd_tag,
    output logic                 rd_hit,
    output logic [DATA_W-1:0]    rd_data,
    input  logic                 wr_en,
    input  logic [LINE_BITS-1:0] wr_idx,
    input  logic [TAG_W-1:0]     wr_tag,
    input  logic [DATA_W-1:0]    wr_data
);
    logic [LINES-1:0]  line_valid;
    logic [TAG_W-1:0]  tag_mem  [LINES];
    logic [DATA_W-1:0] data_mem [LINES];

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            line_valid <= '0;
        end else if (wr_en) begin
            line_valid[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx]  <= wr_tag;
            data_mem[wr_idx] <= wr_data;
        end
    end

    assign rd_hit  = line_valid[rd_idx] && (tag_mem[rd_idx] == rd_tag);
    assign rd_data = data_mem[rd_idx];
endmodule

// File: rtl/rrf_fetch_top.sv
module rrf_fetch_top
    import rrf_pkg::*;
#(
    parameter int SLICES    = 16,
    parameter int LINE_BITS = 8,
    parameter int PC_W      = 16,
    parameter int INSTR_W   = 32,
    parameter logic [INSTR_W-1:0] NOP_WORD = '0,
    localparam int SB = $clog2(SLICES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               redir_valid,
    input  logic [PC_W-1:0]    redir_pc,
    output logic               mem_req,
    output logic [PC_W-1:0]    mem_addr,
    input  logic               mem_rvalid,
    input  logic [INSTR_W-1:0] mem_rdata,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [PC_W-1:0]    out_pc,
    output logic [INSTR_W-1:0] out_instr,
    output logic               out_nop,
    output logic [SB-1:0]      out_slice
);
    localparam int TAG_LSB = SB + LINE_BITS;
    localparam int TAG_W   = PC_W - TAG_LSB;

    fetch_state_t st_q, st_d;
    logic [PC_W-1:0]      pc_q;
    logic                 pend_v;
    logic [PC_W-1:0]      pend_pc;
    logic [SB-1:0]        turn;
    logic [SLICES-1:0]    bank_hit;
    logic [INSTR_W-1:0]   bank_data [SLICES];

    wire [LINE_BITS-1:0] line_idx = pc_q[TAG_LSB-1:SB];
    wire [TAG_W-1:0]     line_tag = pc_q[PC_W-1:TAG_LSB];
    wire                 own_turn = (pc_q[SB-1:0] == turn);
    wire                 at_start = (st_q == ST_LOOKUP);
    wire                 redir_go = at_start && (redir_valid || pend_v);
    wire [PC_W-1:0]      redir_tgt = redir_valid ? redir_pc : pend_pc;
    wire                 sel_hit  = bank_hit[turn];
    wire                 refill_done = (st_q == ST_REFILL) && mem_rvalid;
    wire                 beat_taken  = (st_q == ST_EMIT) && out_ready;

    rrf_turn_ring #(.SLICES(SLICES)) u_ring (
        .clk  (clk),
        .rst_n(rst_n),
        .step (beat_taken),
        .turn (turn)
    );

    for (genvar g = 0; g < SLICES; g++) begin : g_bank
        rrf_slice_cache #(
            .LINE_BITS(LINE_BITS),
            .TAG_W    (TAG_W),
            .DATA_W   (INSTR_W)
        ) u_cache (
            .clk    (clk),
            .rst_n  (rst_n),
            .flush  (flush),
            .rd_idx (line_idx),
            .rd_tag (line_tag),
            .rd_hit (bank_hit[g]),
            .rd_data(bank_data[g]),
            .wr_en  (refill_done && (turn == SB'(g))),
            .wr_idx (line_idx),
            .wr_tag (line_tag),
            .wr_data(mem_rdata)
        );
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_LOOKUP;
        else        st_q <= st_d;
    end

    // next-state decision
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_LOOKUP: begin
                if (redir_go)                 st_d = ST_LOOKUP;
                else if (!own_turn || sel_hit) st_d = ST_EMIT;
                else                          st_d = ST_REFILL;
            end
            ST_REFILL: if (mem_rvalid) st_d = ST_EMIT;
            ST_EMIT:   if (out_ready)  st_d = ST_LOOKUP;
            default:   st_d = ST_LOOKUP;
        endcase
    end

    // PC, pending redirect and output beat
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q      <= '0;
            pend_v    <= 1'b0;
            pend_pc   <= '0;
            out_pc    <= '0;
            out_instr <= '0;
            out_nop   <= 1'b0;
            out_slice <= '0;
        end else begin
            if (!at_start && redir_valid) begin
                pend_v  <= 1'b1;
                pend_pc <= redir_pc;
            end else if (redir_go) begin
                pend_v  <= 1'b0;
            end

            if (redir_go) begin
                pc_q <= redir_tgt;
            end else if (at_start) begin
                out_pc    <= pc_q;
                out_slice <= turn;
                if (!own_turn) begin
                    out_instr <= NOP_WORD;
                    out_nop   <= 1'b1;
                end else if (sel_hit) begin
                    out_instr <= bank_data[turn];
                    out_nop   <= 1'b0;
                    pc_q      <= pc_q + PC_W'(1);
                end
            end else if (refill_done) begin
                out_instr <= mem_rdata;
                out_nop   <= 1'b0;
                pc_q      <= pc_q + PC_W'(1);
            end
        end
    end

    assign out_valid = (st_q == ST_EMIT);
    assign mem_req   = (st_q == ST_REFILL);
    assign mem_addr  = pc_q;
endmodule

// File: rtl/rrf_fetch_checker.sv
module rrf_fetch_checker #(
    parameter int SLICES  = 16,
    parameter int PC_W    = 16,
    parameter int INSTR_W = 32,
    localparam int SB = $clog2(SLICES)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               mem_req,
    input logic [PC_W-1:0]    mem_addr,
    input logic               mem_rvalid,
    input logic               out_valid,
    input logic               out_ready,
    input logic [PC_W-1:0]    out_pc,
    input logic [INSTR_W-1:0] out_instr,
    input logic               out_nop,
    input logic [SB-1:0]      out_slice
);
    logic          seen_beat;
    logic [SB-1:0] last_slice;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_beat  <= 1'b0;
            last_slice <= '0;
        end else if (out_valid && out_ready) begin
            seen_beat  <= 1'b1;
            last_slice <= out_slice;
        end
    end

    wire [SB-1:0] next_slice = (last_slice == SB'(SLICES - 1)) ? '0 : last_slice + SB'(1);

    assert_first_beat_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) && !seen_beat |-> (out_slice == '0) && (out_pc == '0));

    assert_rotation_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) && seen_beat |-> out_slice == next_slice);

    assert_nop_residue_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_nop |-> out_pc[SB-1:0] != out_slice);

    assert_owner_slice_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_nop |-> out_pc[SB-1:0] == out_slice);

    assert_read_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr));

    assert_no_beat_in_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !out_valid);

    assert_beat_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_pc) && $stable(out_instr)
                                    && $stable(out_nop) && $stable(out_slice));
endmodule

bind rrf_fetch_top rrf_fetch_checker #(
    .SLICES (SLICES),
    .PC_W   (PC_W),
    .INSTR_W(INSTR_W)
) u_fetch_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_rvalid(mem_rvalid),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_pc    (out_pc),
    .out_instr (out_instr),
    .out_nop   (out_nop),
    .out_slice (out_slice)
);

// File: tb/test_rrf_fetch_top.sv
`timescale 1ns/1ps
module test_rrf_fetch_top;
    localparam int N  = 4;
    localparam int LB = 2;
    localparam int PW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush = 1'b0;
    logic          redir_valid = 1'b0;
    logic [PW-1:0] redir_pc = '0;
    logic          mem_req;
    logic [PW-1:0] mem_addr;
    logic          mem_rvalid = 1'b0;
    logic [31:0]   mem_rdata = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [PW-1:0] out_pc;
    logic [31:0]   out_instr;
    logic          out_nop;
    logic [1:0]    out_slice;

    int errors = 0;
    int checks = 0;
    int reads  = 0;
    int read_mark = 0;
    bit finished = 1'b0;

    // bench model of the placement rules
    bit            mv [N][1<<LB];
    int            mt [N][1<<LB];
    int            exp_pc = 0;
    int            exp_turn = 0;
    bit            after_redir = 1'b0;
    bit            after_flush = 1'b0;

    always #2 clk = ~clk;

    rrf_fetch_top #(.SLICES(N), .LINE_BITS(LB), .PC_W(PW), .INSTR_W(32)) i_rrf_fetch_top (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .redir_valid(redir_valid), .redir_pc(redir_pc),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_pc(out_pc), .out_instr(out_instr),
        .out_nop(out_nop), .out_slice(out_slice)
    );

    function automatic logic [31:0] word_at(input int a);
        return 32'h5A00_0011 + 32'(a) * 32'd257;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h (pc model %0d)", req, act, exp, exp_pc);
        end
    endtask

    // memory responder: data two cycles after the read starts
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            if (mem_rvalid) begin
                mem_rvalid = 1'b0;
                cnt = 0;
            end else if (mem_req) begin
                cnt++;
                if (cnt == 2) begin
                    mem_rvalid = 1'b1;
                    mem_rdata  = word_at(int'(mem_addr));
                    reads++;
                end
            end else begin
                cnt = 0;
            end
        end
    end

    function automatic bit model_nop();
        return (exp_pc % N) != exp_turn;
    endfunction

    task automatic beat(input int delay, input bit do_redir, input int tgt, input bit do_flush);
        bit nop, miss;
        int idx, tag;
        logic [PW-1:0] h_pc; logic [31:0] h_in; logic h_nop; logic [1:0] h_sl;
        do @(negedge clk); while (!out_valid);
        nop = model_nop();
        idx = (exp_pc / N) % (1 << LB);
        tag = exp_pc / (N << LB);
        miss = !nop && !(mv[exp_turn][idx] && mt[exp_turn][idx] == tag);
        check("R2 slice order", out_slice, exp_turn);
        check(after_redir ? "R9 pc after redirect" : "R4 pc", out_pc, exp_pc);
        check(nop ? "R3 nop flag" : "R4 nop flag", out_nop, nop);
        check(nop ? "R3 nop word" : "R4 instr word", out_instr, nop ? 0 : word_at(exp_pc));
        check(miss ? (after_flush ? "R8 read after flush" : "R5 one read on miss")
                   : "R6 no read on hit", reads - read_mark, miss ? 1 : 0);
        if (!nop) check("R7 owner slice", out_pc % N, out_slice);
        h_pc = out_pc; h_in = out_instr; h_nop = out_nop; h_sl = out_slice;
        if (!nop) begin
            if (miss) begin mv[exp_turn][idx] = 1'b1; mt[exp_turn][idx] = tag; end
            exp_pc = (exp_pc + 1) % (1 << PW);
        end
        exp_turn = (exp_turn + 1) % N;
        after_redir = 1'b0;
        if (miss) after_flush = 1'b0;
        if (do_redir || do_flush) begin
            redir_valid = do_redir; redir_pc = PW'(tgt); flush = do_flush;
            @(negedge clk);
            redir_valid = 1'b0; flush = 1'b0;
            check("R10 hold", {out_valid, h_pc, h_in, h_nop, h_sl}, {1'b1, out_pc, out_instr, out_nop, out_slice});
            if (do_redir) begin exp_pc = tgt; after_redir = 1'b1; end
            if (do_flush) begin
                for (int s = 0; s < N; s++) for (int l = 0; l < (1 << LB); l++) mv[s][l] = 1'b0;
                after_flush = 1'b1;
            end
        end
        for (int d = 0; d < delay; d++) begin
            @(negedge clk);
            check("R10 hold", {out_valid, h_pc, h_in, h_nop, h_sl}, {1'b1, out_pc, out_instr, out_nop, out_slice});
        end
        out_ready = 1'b1;
        @(posedge clk);
        read_mark = reads;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic run_loop(input int base, input int len, input int beats);
        beat(1, 1'b1, base, 1'b0);
        for (int i = 0; i < beats; i++) begin
            bool_redir: begin
                bit r;
                r = !model_nop() && exp_pc == base + len - 1;
                beat(i % 3, r, base, 1'b0);
            end
        end
    endtask

    initial begin
        for (int s = 0; s < N; s++) for (int l = 0; l < (1 << LB); l++) begin mv[s][l] = 1'b0; mt[s][l] = 0; end
        repeat (3) @(negedge clk);
        check("R1 no beat in reset", out_valid, 0);
        check("R1 no read in reset", mem_req, 0);
        rst_n = 1'b1;
        do @(negedge clk); while (!out_valid);
        check("R1 first slice", out_slice, 0);
        check("R1 first pc", out_pc, 0);
        // straight-line code across several tags
        for (int i = 0; i < 40; i++) beat(i % 3, 1'b0, 0, 1'b0);
        // short loops whose length does not divide the slice count
        run_loop(0, 3, 24);
        run_loop(5, 6, 30);
        // same slice and line, different tag: mutual eviction
        run_loop(16, 3, 12);
        run_loop(0, 3, 12);
        run_loop(14, 4, 16);
        // flush, then revisit cached code
        beat(1, 1'b0, 0, 1'b1);
        run_loop(0, 3, 18);
        beat(2, 1'b1, 33, 1'b1);
        for (int i = 0; i < 12; i++) beat(i % 2, 1'b0, 0, 1'b0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule